// File: doc/BRIEF.md
# Channel Group Power and Initialisation Sequencer

This block holds the control state for a bank of echo-canceller channel groups. Each group has two canceller instances that share one control byte. A host reads and writes these bytes through a simple address/data port. Each byte sets three things for its group: whether the group is powered, which PCM law and code format both instances use, and whether each instance's tone-detector interrupt may reach the group's interrupt output.

A powered-down group has its cancellers and tone detectors idle. Its receive and send samples are carried through a frame-clocked delay line instead of the cancellation path. When the power bit of a group goes from 0 to 1, the group becomes active at once and starts a hardware initialisation. The initialisation runs for a fixed number of frame strobes. While it runs, the group's busy flag is high. External stubs use that flag to reload the per-channel registers and clear the filter coefficients. Host writes to the per-channel space are refused while the flag is high.

Frame timing comes from a single-cycle frame strobe input. The cancellation arithmetic, the tone detection and the companding are outside the block. They connect through stub ports: processed samples come in, and interrupt requests come in.

Top module: `grp_power_seq`

## Requirements
- R1: After reset every control byte is 0x00. All groups are inactive and not busy. All coding selects and interrupt outputs are 0.
- R2: The control byte of group g (g = 0 to 14) sits at host address 0x401+g. host_rdata returns the addressed byte combinationally. Other addresses read 0x00, and writes to them change nothing.
- R3: Field layout: bit 0 is power, bit 1 is A-law (1) or mu-law (0), bit 2 is G.711 code (1) or sign-magnitude (0), bit 3 masks instance A's interrupt, and bit 4 masks instance B's interrupt. Bits 7:5 always read 0 and ignore writes.
- R4: sel_alaw[g] and sel_itu[g] follow bits 1 and 2 of group g's byte. These selects apply to both instances of the group.
- R5: irq_grp[g] is high only when ec_active[g] is high and an unmasked interrupt request is present. An A request counts when bit 3 is 0, and a B request counts when bit 4 is 0.
- R6: Each group has a two-stage delay line per direction that shifts on every frame strobe. While ec_active[g] is 0, rout/sout carry the value rin/sin had at the strobe before the last strobe. While ec_active[g] is 1, they carry ec_rout_in/ec_sout_in.
- R7: A write that changes the power bit from 0 to 1 sets ec_active and init_busy on the next cycle. init_busy drops on the clock edge of the second frame strobe that follows the write. A strobe in the same cycle as the write does not count.
- R8: When the power bit is written to 0, ec_active falls at the first frame strobe at or after the write. init_busy clears on the next edge, abandoning any initialisation in progress.
- R9: chan_we_ok is high only when chan_we is high, chan_grp names an existing group, and that group's init_busy is low.
- R10: Writing a byte with bit 0 set to a group already powered does not restart the initialisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | One-cycle pulse per 8 kHz frame |
| host_addr | input | 12 | Host register address |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| chan_we | input | 1 | Host write request to a group's per-channel space |
| chan_grp | input | 4 | Group index of that request |
| chan_we_ok | output | 1 | Per-channel write accepted |
| td_irq_a | input | 15 | Tone-detector requests, instance A, per group |
| td_irq_b | input | 15 | Tone-detector requests, instance B, per group |
| irq_grp | output | 15 | Gated interrupt per group |
| sel_alaw | output | 15 | A-law select per group |
| sel_itu | output | 15 | G.711 code select per group |
| init_busy | output | 15 | Initialisation running per group |
| ec_active | output | 15 | Group powered and processing |
| rin_in | input | 120 | Receive-in samples, 8 bits per group |
| sin_in | input | 120 | Send-in samples, 8 bits per group |
| ec_rout_in | input | 120 | Processed receive samples from the canceller stub |
| ec_sout_in | input | 120 | Processed send samples from the canceller stub |
| rout_out | output | 120 | Receive-out samples |
| sout_out | output | 120 | Send-out samples |

## Verification
The hardest cases to reach are the collisions between host writes and frame strobes. A power-up write can land in the same cycle as a strobe, which must not count toward the initialisation. A power-down write can coincide with a strobe, which must drop the group at once. A power bit can also be cleared while an initialisation is still counting. The bench drives each of these collisions directly. A long random run then uses dense strobes and biased addresses, so that writes regularly meet strobes and busy periods. Every output is compared each cycle against a frame-by-frame model.

// File: rtl/grp_power_seq.sv
module grp_power_seq #(
  parameter int GROUPS      = 15,
  parameter int SAMPLE_W    = 8,
  parameter int ADDR_W      = 12,
  parameter int BASE_ADDR   = 'h401,
  parameter int INIT_FRAMES = 2,
  localparam int IDX_W = $clog2(GROUPS + 1),
  localparam int BUS_W = GROUPS * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_strobe,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              chan_we,
  input  logic [IDX_W-1:0]  chan_grp,
  output logic              chan_we_ok,
  input  logic [GROUPS-1:0] td_irq_a,
  input  logic [GROUPS-1:0] td_irq_b,
  output logic [GROUPS-1:0] irq_grp,
  output logic [GROUPS-1:0] sel_alaw,
  output logic [GROUPS-1:0] sel_itu,
  output logic [GROUPS-1:0] init_busy,
  output logic [GROUPS-1:0] ec_active,
  input  logic [BUS_W-1:0]  rin_in,
  input  logic [BUS_W-1:0]  sin_in,
  input  logic [BUS_W-1:0]  ec_rout_in,
  input  logic [BUS_W-1:0]  ec_sout_in,
  output logic [BUS_W-1:0]  rout_out,
  output logic [BUS_W-1:0]  sout_out
);
  localparam int CNT_W = $clog2(INIT_FRAMES + 1);
  localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] GRP_L  = ADDR_W'(GROUPS);

  logic [ADDR_W-1:0] offs;
  logic              in_range;
  logic              unused_hi;

  assign offs      = host_addr - BASE_L;
  assign in_range  = (host_addr >= BASE_L) && (offs < GRP_L);
  assign unused_hi = ^host_wdata[7:5];

  logic [GROUPS-1:0][4:0] ctrl_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic              wr_hit;
    logic [4:0]        ctrl_nxt;
    logic              pwr_rise;
    logic              pe_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SAMPLE_W-1:0] r1_q, r2_q, s1_q, s2_q;

    assign wr_hit   = host_we && in_range && (offs == ADDR_W'(g));
    assign ctrl_nxt = wr_hit ? host_wdata[4:0] : ctrl_q[g];
    assign pwr_rise = ctrl_nxt[0] && !ctrl_q[g][0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[g] <= '0;
        pe_q      <= 1'b0;
        cnt_q     <= '0;
      end else begin
        ctrl_q[g] <= ctrl_nxt;
        if (ctrl_nxt[0])       pe_q <= 1'b1;
        else if (frame_strobe) pe_q <= 1'b0;
        if (pwr_rise)                         cnt_q <= CNT_W'(INIT_FRAMES);
        else if (!ctrl_nxt[0])                cnt_q <= '0;
        else if (frame_strobe && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r1_q <= '0; r2_q <= '0; s1_q <= '0; s2_q <= '0;
      end else if (frame_strobe) begin
        r1_q <= rin_in[g*SAMPLE_W +: SAMPLE_W];
        r2_q <= r1_q;
        s1_q <= sin_in[g*SAMPLE_W +: SAMPLE_W];
        s2_q <= s1_q;
      end
    end

    assign ec_active[g] = pe_q;
    assign init_busy[g] = (cnt_q != '0);
    assign sel_alaw[g]  = ctrl_q[g][1];
    assign sel_itu[g]   = ctrl_q[g][2];
    assign irq_grp[g]   = pe_q && ((td_irq_a[g] && !ctrl_q[g][3]) ||
                                   (td_irq_b[g] && !ctrl_q[g][4]));
    assign rout_out[g*SAMPLE_W +: SAMPLE_W] = pe_q ? ec_rout_in[g*SAMPLE_W +: SAMPLE_W] : r2_q;
    assign sout_out[g*SAMPLE_W +: SAMPLE_W] = pe_q ? ec_sout_in[g*SAMPLE_W +: SAMPLE_W] : s2_q;
  end

  always_comb begin
    host_rdata = 8'h00;
    chan_we_ok = 1'b0;
    for (int g = 0; g < GROUPS; g++) begin
      if (in_range && offs == ADDR_W'(g)) host_rdata = {3'b000, ctrl_q[g]};
      if (chan_grp == IDX_W'(g))          chan_we_ok = chan_we && !init_busy[g];
    end
  end
endmodule

// File: rtl/grp_power_seq_chk.sv
module grp_power_seq_chk #(
  parameter int GROUPS   = 15,
  parameter int SAMPLE_W = 8,
  localparam int BUS_W = GROUPS * SAMPLE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_strobe,
  input logic              host_we,
  input logic [7:0]        host_rdata,
  input logic              chan_we,
  input logic              chan_we_ok,
  input logic [GROUPS-1:0] td_irq_a,
  input logic [GROUPS-1:0] td_irq_b,
  input logic [GROUPS-1:0] irq_grp,
  input logic [GROUPS-1:0] init_busy,
  input logic [GROUPS-1:0] ec_active,
  input logic [BUS_W-1:0]  rout_out
);
  a_r3_unused_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[7:5] == 3'b000);

  a_r5_irq_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_grp & ~((td_irq_a | td_irq_b) & ec_active)) == '0);

  a_r7_busy_only_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    (init_busy & ~ec_active) == '0);

  a_r7_busy_starts_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((init_busy & ~$past(init_busy)) != '0) |-> $past(host_we));

  a_r8_drop_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ec_active & $past(ec_active)) != '0) |-> $past(frame_strobe));

  a_r6_bypass_holds_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_strobe && ec_active == '0) |=> (ec_active != '0 || $stable(rout_out)));

  a_r9_accept_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    chan_we_ok |-> chan_we);
endmodule

bind grp_power_seq grp_power_seq_chk #(.GROUPS(GROUPS), .SAMPLE_W(SAMPLE_W)) chk_i (.*);

// File: tb/grp_power_seq_tb_top.sv
module grp_power_seq_tb_top;
  localparam int G = 15;
  localparam int W = 8;
  localparam int BW = G * W;
  localparam int BASE = 'h401;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_strobe = 1'b0;
  logic [11:0] host_addr = '0;
  logic host_we = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic chan_we = 1'b0;
  logic [3:0] chan_grp = '0;
  logic chan_we_ok;
  logic [G-1:0] td_irq_a = '0, td_irq_b = '0;
  logic [G-1:0] irq_grp, sel_alaw, sel_itu, init_busy, ec_active;
  logic [BW-1:0] rin_in = '0, sin_in = '0, ec_rout_in = '0, ec_sout_in = '0;
  logic [BW-1:0] rout_out, sout_out;

  always #4 clk = ~clk;

  grp_power_seq dut_i (.*);

  int checks = 0, errors = 0;
  logic [4:0] m_ctrl [G];
  bit         m_pe   [G];
  int         m_cnt  [G];
  logic [W-1:0] m_r1 [G], m_r2 [G], m_s1 [G], m_s2 [G];

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int g = 0; g < G; g++) begin
      m_ctrl[g] = '0; m_pe[g] = 0; m_cnt[g] = 0;
      m_r1[g] = '0; m_r2[g] = '0; m_s1[g] = '0; m_s2[g] = '0;
    end
  endtask

  task automatic model_edge();
    for (int g = 0; g < G; g++) begin
      logic [4:0] nc;
      nc = (host_we && host_addr == 12'(BASE + g)) ? host_wdata[4:0] : m_ctrl[g];
      if (nc[0] && !m_ctrl[g][0]) m_cnt[g] = 2;
      else if (!nc[0]) m_cnt[g] = 0;
      else if (frame_strobe && m_cnt[g] > 0) m_cnt[g]--;
      if (nc[0]) m_pe[g] = 1;
      else if (frame_strobe) m_pe[g] = 0;
      if (frame_strobe) begin
        m_r2[g] = m_r1[g]; m_r1[g] = rin_in[g*W +: W];
        m_s2[g] = m_s1[g]; m_s1[g] = sin_in[g*W +: W];
      end
      m_ctrl[g] = nc;
    end
  endtask

  function automatic logic [7:0] exp_rdata(logic [11:0] a);
    if (a >= 12'(BASE) && a < 12'(BASE + G)) return {3'b000, m_ctrl[a - 12'(BASE)]};
    return 8'h00;
  endfunction

  task automatic check_all();
    logic [G-1:0] e_irq, e_al, e_itu, e_busy, e_act;
    logic [BW-1:0] e_r, e_s;
    logic e_ok;
    e_ok = 1'b0;
    for (int g = 0; g < G; g++) begin
      e_act[g]  = m_pe[g];
      e_busy[g] = (m_cnt[g] != 0);
      e_al[g]   = m_ctrl[g][1];
      e_itu[g]  = m_ctrl[g][2];
      e_irq[g]  = m_pe[g] && ((td_irq_a[g] && !m_ctrl[g][3]) || (td_irq_b[g] && !m_ctrl[g][4]));
      e_r[g*W +: W] = m_pe[g] ? ec_rout_in[g*W +: W] : m_r2[g];
      e_s[g*W +: W] = m_pe[g] ? ec_sout_in[g*W +: W] : m_s2[g];
      if (chan_grp == 4'(g)) e_ok = chan_we && (m_cnt[g] == 0);
    end
    chk("R2", "host_rdata", 128'(host_rdata), 128'(exp_rdata(host_addr)));
    chk("R9", "chan_we_ok", 128'(chan_we_ok), 128'(e_ok));
    chk("R5", "irq_grp", 128'(irq_grp), 128'(e_irq));
    chk("R4", "sel_alaw", 128'(sel_alaw), 128'(e_al));
    chk("R4", "sel_itu", 128'(sel_itu), 128'(e_itu));
    chk("R7", "init_busy", 128'(init_busy), 128'(e_busy));
    chk("R8", "ec_active", 128'(ec_active), 128'(e_act));
    chk("R6", "rout_out", 128'(rout_out), 128'(e_r));
    chk("R6", "sout_out", 128'(sout_out), 128'(e_s));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    host_we = 0; frame_strobe = 0; chan_we = 0;
  endtask

  task automatic wr(int grp, logic [7:0] d, bit fr);
    host_addr = 12'(BASE + grp); host_wdata = d; host_we = 1; frame_strobe = fr;
    step();
    idle();
  endtask

  task automatic strobe();
    frame_strobe = 1; step(); frame_strobe = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd7));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    host_addr = 12'h401;
    #1;
    chk("R1", "ec_active", 128'(ec_active), 128'(0));
    chk("R1", "init_busy", 128'(init_busy), 128'(0));
    chk("R1", "rdata", 128'(host_rdata), 128'(0));
    chk("R1", "sel_alaw", 128'(sel_alaw | sel_itu | irq_grp), 128'(0));

    // R3: unused bits ignore writes and read zero
    wr(5, 8'hE0, 0);
    host_addr = 12'h406; #1;
    chk("R3", "unused bits", 128'(host_rdata), 128'(0));

    // R2: out-of-map addresses
    host_addr = 12'h400; host_wdata = 8'h1F; host_we = 1; step();
    host_addr = 12'h410; step(); idle();
    chk("R2", "no group powered", 128'(ec_active), 128'(0));

    // R7: power-up in a strobe cycle, then two strobes
    wr(2, 8'h07, 1);
    chk("R7", "busy after write", 128'(init_busy[2]), 128'(1));
    step();
    strobe();
    chk("R7", "busy after 1 strobe", 128'(init_busy[2]), 128'(1));
    step();
    strobe();
    chk("R7", "busy after 2 strobes", 128'(init_busy[2]), 128'(0));

    // R10: rewrite with power held does not restart
    wr(2, 8'h19, 0);
    chk("R10", "no restart", 128'(init_busy[2]), 128'(0));

    // R8: power-down waits for strobe; abandon running init
    wr(2, 8'h00, 0);
    chk("R8", "active until strobe", 128'(ec_active[2]), 128'(1));
    strobe();
    chk("R8", "inactive after strobe", 128'(ec_active[2]), 128'(0));
    wr(7, 8'h01, 0);
    wr(7, 8'h00, 1);
    chk("R8", "same-cycle drop", 128'(ec_active[7]), 128'(0));
    chk("R8", "init abandoned", 128'(init_busy[7]), 128'(0));

    // R9: per-channel write refused while busy
    wr(9, 8'h01, 0);
    chan_we = 1; chan_grp = 4'd9; #1;
    chk("R9", "refused while busy", 128'(chan_we_ok), 128'(0));
    chan_grp = 4'd15; #1;
    chk("R9", "no such group", 128'(chan_we_ok), 128'(0));
    chan_we = 0;

    for (int i = 0; i < 6000; i++) begin
      frame_strobe = ($urandom_range(0, 4) == 0);
      host_we      = ($urandom_range(0, 2) == 0);
      host_addr    = 12'($urandom_range('h3FE, 'h412));
      host_wdata   = 8'($urandom);
      chan_we      = $urandom_range(0, 1);
      chan_grp     = 4'($urandom_range(0, 15));
      td_irq_a     = G'($urandom);
      td_irq_b     = G'($urandom);
      for (int g = 0; g < G; g++) begin
        rin_in[g*W +: W]     = W'($urandom);
        sin_in[g*W +: W]     = W'($urandom);
        ec_rout_in[g*W +: W] = W'($urandom);
        ec_sout_in[g*W +: W] = W'($urandom);
      end
      step();
    end
    idle();
    summary();
  end
endmodule